// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block translates a 48-bit virtual address into a 52-bit physical address by walking a radix tree of page tables held in memory. The virtual address carries four 9-bit table indices above a 12-bit byte offset. The walk starts at the table whose 4 KB frame number comes from a root-frame input. At each of the four levels the block reads one 64-bit entry, checks it, and then either moves to the frame the entry names or stops with a fault.

When an entry passes its checks and its accessed flag is clear, the block writes the entry back to memory with that flag set. For a write access it also sets the dirty flag in the last-level entry. Each write-back finishes before the next level is read. A walk that succeeds returns the last-level frame joined to the page offset. A walk that fails returns a fault code and the level that stopped it.

The block accepts one request at a time and holds its response until the response handshake completes. A CPU memory-management unit would use it behind a translation cache, on every miss in that cache.

Top module: `pt_walker`

## Requirements
- R1: At level k (1 to 4) the entry is read at byte address `(frame << 12) + 8 * index_k`. The indices come from the virtual address bits 47:39, 38:30, 29:21 and 20:12, in that order. Level 1 uses `rootFrame` as its frame, sampled when the request is accepted.
- R2: The next frame is taken only from entry bits 51:12. Entry bits 63:52 and the bits below 12 that are not flags have no effect on any address.
- R3: An entry with bit 0 (present) clear ends the walk with `rspCode` = 1 and `rspLevel` = the level of that entry (1 to 4). The entry is not written.
- R4: A user access (`reqUser` = 1) that reaches an entry with bit 2 (user-allowed) clear ends the walk with `rspCode` = 3 at that level. This check comes after the present check and before the write check.
- R5: A write access (`reqWrite` = 1) that reaches an entry with bit 1 (writable) clear ends the walk with `rspCode` = 2 at that level.
- R6: Every entry that passes its checks has bit 5 (accessed) set in memory once the walk ends. On a write access, bit 6 (dirty) of the level-4 entry is set. Bit 6 of the entries at levels 1 to 3 and all other entry bits are left unchanged.
- R7: An entry is written back only when setting those flags changes it. The write completes before the next level is read. An entry that raises a fault is never written.
- R8: A successful walk returns `rspCode` = 0, `rspLevel` = 0 and `rspPaddr` = {level-4 entry bits 51:12, virtual address bits 11:0}. On a fault, `rspPaddr` is zero.
- R9: `reqReady` is low from the cycle after a request is accepted until the response handshake completes. While `rspValid` is high and `rspReady` is low, the response holds steady.
- R10: A memory request (`memValid`) keeps its address, direction and write data stable until `memReady` is high. A memory request and a response are never presented in the same cycle.
- R11: During and right after reset, `reqReady` is 1, and `memValid` and `rspValid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| rootFrame | input | 40 | Frame number of the level-1 table |
| reqValid | input | 1 | Translation request valid |
| reqReady | output | 1 | Block can accept a request |
| reqVaddr | input | 48 | Virtual address to translate |
| reqWrite | input | 1 | Access is a write |
| reqUser | input | 1 | Access is from user mode |
| memValid | output | 1 | Memory access request |
| memWrite | output | 1 | Memory access is a write |
| memAddr | output | 52 | Byte address of the 64-bit entry |
| memWdata | output | 64 | Entry value to write back |
| memReady | input | 1 | Memory accepts the access; read data valid this cycle |
| memRdata | input | 64 | Read data, valid while memReady is high on a read |
| rspValid | output | 1 | Response valid |
| rspReady | input | 1 | Response consumer ready |
| rspPaddr | output | 52 | Translated physical address (zero on fault) |
| rspCode | output | 2 | 0 ok, 1 not present, 2 write-protected, 3 user-protected |
| rspLevel | output | 3 | Faulting level 1 to 4, or 0 on success |

## Verification
The bench runs several hundred walks with random indices and random flags on every level. It compares each result with a software walk over a mirror of memory. The checks look for the fault priority going wrong, such as a write fault reported where the user fault should win, and for a fault reported at the wrong level. They also look for the dirty flag leaking into upper-level entries and for entries rewritten when nothing changed, which shows up as extra write cycles. Junk placed in entry bits 63:52 catches a frame field sliced too wide, since that would send the next read outside the tables. Random stalls on memory and on the response catch a request or response that drifts while it waits.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

  localparam int BIT_PRESENT  = 0;
  localparam int BIT_WRITABLE = 1;
  localparam int BIT_USER     = 2;
  localparam int BIT_ACCESSED = 5;
  localparam int BIT_DIRTY    = 6;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_ABSENT = 2'd1,
    FLT_WRITE  = 2'd2,
    FLT_USER   = 2'd3
  } fault_e;

  typedef struct packed {
    logic loadReq;
    logic latchEntry;
    logic descend;
    logic latchFault;
  } dp_ctrl_t;

endpackage

// File: rtl/pt_walk_dp.sv
module pt_walk_dp
  import pt_walk_pkg::*;
#(
  parameter int VA_W   = 48,
  parameter int PA_W   = 52,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  parameter int LEVELS = 4,
  parameter int ENT_W  = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  dp_ctrl_t            ctrl,
  input  logic [PA_W-OFF_W-1:0] rootFrame,
  input  logic [VA_W-1:0]     reqVaddr,
  input  logic                reqWrite,
  input  logic                reqUser,
  input  logic [ENT_W-1:0]    memRdata,
  output logic [PA_W-1:0]     memAddr,
  output logic [ENT_W-1:0]    memWdata,
  output logic                isFault,
  output logic                needWb,
  output logic                lastLevel,
  output logic [PA_W-1:0]     rspPaddr,
  output logic [1:0]          rspCode,
  output logic [2:0]          rspLevel
);

  localparam int FRAME_W = PA_W - OFF_W;
  localparam int LVL_W   = $clog2(LEVELS);
  localparam int ENT_SH  = OFF_W - IDX_W;

  logic [VA_W-1:0]    vaReg;
  logic               wrReg, usrReg;
  logic [FRAME_W-1:0] frameReg;
  logic [LVL_W-1:0]   lvlReg;
  logic [ENT_W-1:0]   entryReg;
  fault_e             codeReg, faultNow;
  logic [2:0]         faultLvlReg;
  logic [IDX_W-1:0]   idxAll [LEVELS];

  // Level g (0-based) takes the index field g places below the top of the address.
  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idxAll[g] = vaReg[OFF_W + IDX_W*(LEVELS-1-g) +: IDX_W];
  end

  assign lastLevel = (lvlReg == LVL_W'(LEVELS-1));
  assign memAddr   = {frameReg, idxAll[lvlReg], {ENT_SH{1'b0}}};

  always_comb begin
    memWdata = entryReg;
    memWdata[BIT_ACCESSED] = 1'b1;
    if (lastLevel && wrReg) memWdata[BIT_DIRTY] = 1'b1;
  end
  assign needWb = (memWdata != entryReg);

  // Priority: present, then user, then write.
  always_comb begin
    if (!entryReg[BIT_PRESENT])                 faultNow = FLT_ABSENT;
    else if (usrReg && !entryReg[BIT_USER])     faultNow = FLT_USER;
    else if (wrReg && !entryReg[BIT_WRITABLE])  faultNow = FLT_WRITE;
    else                                        faultNow = FLT_NONE;
  end
  assign isFault = (faultNow != FLT_NONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaReg       <= '0;
      wrReg       <= 1'b0;
      usrReg      <= 1'b0;
      frameReg    <= '0;
      lvlReg      <= '0;
      entryReg    <= '0;
      codeReg     <= FLT_NONE;
      faultLvlReg <= '0;
    end else begin
      if (ctrl.loadReq) begin
        vaReg       <= reqVaddr;
        wrReg       <= reqWrite;
        usrReg      <= reqUser;
        frameReg    <= rootFrame;
        lvlReg      <= '0;
        codeReg     <= FLT_NONE;
        faultLvlReg <= '0;
      end
      if (ctrl.latchEntry) entryReg <= memRdata;
      if (ctrl.descend) begin
        frameReg <= entryReg[PA_W-1:OFF_W];
        lvlReg   <= lvlReg + 1'b1;
      end
      if (ctrl.latchFault) begin
        codeReg     <= faultNow;
        faultLvlReg <= {{(3-LVL_W){1'b0}}, lvlReg} + 3'd1;
      end
    end
  end

  assign rspCode  = codeReg;
  assign rspLevel = faultLvlReg;
  assign rspPaddr = (codeReg == FLT_NONE) ? {entryReg[PA_W-1:OFF_W], vaReg[OFF_W-1:0]} : '0;

endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
  import pt_walk_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     memReady,
  input  logic     rspReady,
  input  logic     isFault,
  input  logic     needWb,
  input  logic     lastLevel,
  output logic     reqReady,
  output logic     memValid,
  output logic     memWrite,
  output logic     rspValid,
  output dp_ctrl_t ctrl
);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_CHECK, S_STORE, S_REPLY} state_e;
  state_e state, nextState;

  always_comb begin
    nextState = state;
    ctrl      = '0;
    reqReady  = 1'b0;
    memValid  = 1'b0;
    memWrite  = 1'b0;
    rspValid  = 1'b0;
    unique case (state)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          ctrl.loadReq = 1'b1;
          nextState    = S_FETCH;
        end
      end
      S_FETCH: begin
        memValid = 1'b1;
        if (memReady) begin
          ctrl.latchEntry = 1'b1;
          nextState       = S_CHECK;
        end
      end
      S_CHECK: begin
        if (isFault) begin
          ctrl.latchFault = 1'b1;
          nextState       = S_REPLY;
        end else if (needWb) begin
          nextState = S_STORE;
        end else if (lastLevel) begin
          nextState = S_REPLY;
        end else begin
          ctrl.descend = 1'b1;
          nextState    = S_FETCH;
        end
      end
      S_STORE: begin
        memValid = 1'b1;
        memWrite = 1'b1;
        if (memReady) begin
          if (lastLevel) nextState = S_REPLY;
          else begin
            ctrl.descend = 1'b1;
            nextState    = S_FETCH;
          end
        end
      end
      S_REPLY: begin
        rspValid = 1'b1;
        if (rspReady) nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  assert_one_walk_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(memValid && rspValid));

  assert_ready_blocked_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> (rspValid && !reqReady));

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
#(
  parameter int VA_W   = 48,
  parameter int PA_W   = 52,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  parameter int LEVELS = 4,
  parameter int ENT_W  = 64
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [PA_W-OFF_W-1:0] rootFrame,
  input  logic                  reqValid,
  output logic                  reqReady,
  input  logic [VA_W-1:0]       reqVaddr,
  input  logic                  reqWrite,
  input  logic                  reqUser,
  output logic                  memValid,
  output logic                  memWrite,
  output logic [PA_W-1:0]       memAddr,
  output logic [ENT_W-1:0]      memWdata,
  input  logic                  memReady,
  input  logic [ENT_W-1:0]      memRdata,
  output logic                  rspValid,
  input  logic                  rspReady,
  output logic [PA_W-1:0]       rspPaddr,
  output logic [1:0]            rspCode,
  output logic [2:0]            rspLevel
);

  dp_ctrl_t ctrl;
  logic     isFault, needWb, lastLevel;

  pt_walk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memReady(memReady),
    .rspReady(rspReady), .isFault(isFault), .needWb(needWb), .lastLevel(lastLevel),
    .reqReady(reqReady), .memValid(memValid), .memWrite(memWrite),
    .rspValid(rspValid), .ctrl(ctrl)
  );

  pt_walk_dp #(
    .VA_W(VA_W), .PA_W(PA_W), .IDX_W(IDX_W), .OFF_W(OFF_W),
    .LEVELS(LEVELS), .ENT_W(ENT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .rootFrame(rootFrame),
    .reqVaddr(reqVaddr), .reqWrite(reqWrite), .reqUser(reqUser),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .isFault(isFault), .needWb(needWb), .lastLevel(lastLevel),
    .rspPaddr(rspPaddr), .rspCode(rspCode), .rspLevel(rspLevel)
  );

  assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memWrite) && $stable(memAddr) && $stable(memWdata)));

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> (rspValid && $stable(rspPaddr) && $stable(rspCode) && $stable(rspLevel)));

  assert_wb_accessed_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memWrite) |-> memWdata[BIT_ACCESSED]);

  assert_wb_present_R7: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memWrite) |-> memWdata[BIT_PRESENT]);

  assert_fault_level_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspCode != 2'd0) |-> (rspLevel >= 3'd1 && rspLevel <= 3'd4 && rspPaddr == '0));

  assert_ok_level_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspCode == 2'd0) |-> (rspLevel == 3'd0));

endmodule

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic [39:0] rootFrame;
  logic        reqValid, reqReady, reqWrite, reqUser;
  logic [47:0] reqVaddr;
  logic        memValid, memWrite, memReady;
  logic [51:0] memAddr;
  logic [63:0] memWdata, memRdata;
  logic        rspValid, rspReady;
  logic [51:0] rspPaddr;
  logic [1:0]  rspCode;
  logic [2:0]  rspLevel;

  always #10 clk = ~clk;

  pt_walker dut_i (
    .clk(clk), .rstN(rstN), .rootFrame(rootFrame),
    .reqValid(reqValid), .reqReady(reqReady), .reqVaddr(reqVaddr),
    .reqWrite(reqWrite), .reqUser(reqUser),
    .memValid(memValid), .memWrite(memWrite), .memAddr(memAddr),
    .memWdata(memWdata), .memReady(memReady), .memRdata(memRdata),
    .rspValid(rspValid), .rspReady(rspReady), .rspPaddr(rspPaddr),
    .rspCode(rspCode), .rspLevel(rspLevel)
  );

  // Tables live in frames 0..3; memory word index = byte address bits 13:3.
  logic [63:0] mem    [0:2047];
  logic [63:0] refMem [0:2047];
  int checks = 0, errors = 0, memWrites = 0, cycles = 0;
  logic [63:0] rng = 64'h9E3779B97F4A7C15;

  function automatic logic [63:0] nextRand();
    rng ^= rng << 13;
    rng ^= rng >> 7;
    rng ^= rng << 17;
    return rng;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  assign memRdata = mem[memAddr[13:3]];

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (memValid && memReady && memWrite) begin
      mem[memAddr[13:3]] <= memWdata;
      memWrites <= memWrites + 1;
    end
  end

  // R10: random memory stalls; R1/R2: every access must stay inside the tables.
  always @(negedge clk) begin
    memReady <= (nextRand() % 3) != 0;
    if (rstN && memValid && memAddr[51:14] != '0)
      check(1'b0, "R1", "address outside tables", {12'h0, memAddr}, 64'h0);
  end

  always @(posedge clk) begin
    if (cycles == 190000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic doWalk(input logic [47:0] va, input bit wr, input bit us);
    logic [39:0] frame;
    logic [63:0] e, ne;
    logic [10:0] ix [4];
    int expWrites = 0, expCode = 0, expLvl = 0, touched = 0, startW, t;
    logic [51:0] expPa = '0;
    string tag;
    frame = 40'd0;
    for (int l = 0; l < 4; l++) begin
      ix[l] = {frame[1:0], va[12 + 9*(3-l) +: 9]};
      e = refMem[ix[l]];
      touched = l + 1;
      if (!e[0])              begin expCode = 1; expLvl = l + 1; break; end
      else if (us && !e[2])   begin expCode = 3; expLvl = l + 1; break; end
      else if (wr && !e[1])   begin expCode = 2; expLvl = l + 1; break; end
      ne = e; ne[5] = 1'b1;
      if (l == 3 && wr) ne[6] = 1'b1;
      if (ne != e) begin refMem[ix[l]] = ne; expWrites++; end
      frame = e[51:12];
    end
    if (expCode == 0) expPa = {frame, va[11:0]};
    tag = (expCode == 1) ? "R3" : (expCode == 3) ? "R4" : (expCode == 2) ? "R5" : "R8";

    startW = memWrites;
    @(negedge clk);
    reqValid = 1'b1; reqVaddr = va; reqWrite = wr; reqUser = us;
    @(negedge clk);
    reqValid = 1'b0;
    check(reqReady == 1'b0, "R9", "ready low after accept", reqReady, 0);
    t = 0;
    while (!rspValid && t < 300) begin @(negedge clk); t++; end
    repeat (nextRand() % 3) begin
      @(negedge clk);
      check(reqReady == 1'b0, "R9", "ready low while response waits", reqReady, 0);
    end
    check(rspValid == 1'b1, tag, "response arrived", rspValid, 1);
    check(rspCode == 2'(expCode), tag, "fault code", rspCode, expCode);
    check(rspLevel == 3'(expLvl), tag, "fault level", rspLevel, expLvl);
    check(rspPaddr == expPa, "R8", "physical address", rspPaddr, expPa);
    rspReady = 1'b1;
    @(negedge clk);
    rspReady = 1'b0;
    check(memWrites - startW == expWrites, "R7", "write-back count", memWrites - startW, expWrites);
    for (int l = 0; l < touched; l++)
      check(mem[ix[l]] == refMem[ix[l]], "R6", "entry after walk", mem[ix[l]], refMem[ix[l]]);
    check(reqReady == 1'b1, "R9", "ready after response", reqReady, 1);
  endtask

  initial begin
    rstN = 1'b0; reqValid = 1'b0; rspReady = 1'b0; reqVaddr = '0;
    reqWrite = 1'b0; reqUser = 1'b0; rootFrame = 40'd0; memReady = 1'b0;
    for (int i = 0; i < 2048; i++) begin mem[i] = '0; refMem[i] = '0; end
    repeat (3) @(negedge clk);
    check(reqReady == 1'b1, "R11", "reqReady in reset", reqReady, 1);
    check(memValid == 1'b0, "R11", "memValid in reset", memValid, 0);
    check(rspValid == 1'b0, "R11", "rspValid in reset", rspValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1 && rspValid == 1'b0, "R11", "idle after reset", reqReady, 1);

    // R1 R2 R3 R4 R5 R6 R7 R8: random tables and flags on every level.
    for (int n = 0; n < 700; n++) begin
      logic [8:0]  idx [4];
      logic [63:0] r, ent;
      logic [47:0] va;
      for (int l = 0; l < 4; l++) idx[l] = 9'(nextRand());
      va = {idx[0], idx[1], idx[2], idx[3], 12'(nextRand())};
      for (int l = 0; l < 4; l++) begin
        r = nextRand();
        ent = r;
        ent[51:12] = (l == 3) ? 40'(nextRand()) : 40'(l + 1);
        ent[0] = (r[3:0]  != 4'd0);
        ent[1] = (r[14:12] != 3'd0);
        ent[2] = (r[22:20] != 3'd0);
        mem[{l[1:0], idx[l]}]    = ent;
        refMem[{l[1:0], idx[l]}] = ent;
      end
      doWalk(va, n[0], n[1]);
    end

    // R7: repeat a successful write walk; the second pass rewrites nothing.
    for (int l = 0; l < 4; l++) begin
      logic [63:0] ent;
      ent = 64'hFFF0_0000_0000_0E07;
      ent[51:12] = (l == 3) ? 40'hABCDE12345 : 40'(l + 1);
      mem[{l[1:0], 9'(l + 5)}] = ent;
      refMem[{l[1:0], 9'(l + 5)}] = ent;
    end
    doWalk({9'd5, 9'd6, 9'd7, 9'd8, 12'h3C4}, 1'b1, 1'b1);
    doWalk({9'd5, 9'd6, 9'd7, 9'd8, 12'h3C4}, 1'b1, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule